// File: doc/BRIEF.md
# HDB3 Receive Decoder

This block turns the received line signal into a plain NRZ bit stream, one bit per clock. A mode input picks the source. In dual-rail mode a positive and a negative pulse rail arrive in HDB3 code. The block strips the zero-substitution groups and reports every code violation that no substitution explains. In NRZ mode the single data input passes through the same alignment delay, so the output timing does not depend on the mode.

Each illegal violation gives a one-cycle pulse on `cv_o` and adds one to a saturating counter. A processor reads the counter with a strobe, and the read also clears it. A separate clear input zeroes the counter without a read. A line clock output follows the block clock and can be inverted in dual-rail mode.

Top module: `hdb3_rx_decoder`

## Requirements
- R1: While `rst_ni` is low, `data_o`, `cv_o`, `cnt_o` and `rd_data_o` are all 0.
- R2: With `dual_rail_i` = 0, the `nrz_i` value sampled at rising edge k appears on `data_o` after rising edge k+3, and `pos_i`/`neg_i` have no effect on it.
- R3: With `dual_rail_i` = 1, a cycle with exactly one rail high is a mark and decodes to 1, a cycle with both rails low decodes to 0, and the latency is the same as in R2. A rail high means the pulse polarity: `pos_i` is positive and `neg_i` is negative.
- R4: A single-rail pulse has the same polarity as the previous single-rail pulse, and neither of the two bit periods just before it held a mark. This pulse is a substitution: it and the three bit periods before it decode to 0. This covers both the 000V and B00V forms.
- R5: A single-rail pulse has the same polarity as the previous single-rail pulse, and a mark sits in one of the two bit periods just before it. This pulse is an illegal violation and decodes to 1.
- R6: A cycle with both rails high is an illegal violation. It decodes to 1 and leaves the recorded previous pulse polarity unchanged.
- R7: An illegal violation sampled at edge k drives `cv_o` high for exactly the cycle after edge k. In NRZ mode `cv_o` stays 0.
- R8: `cnt_o` rises by one for each illegal violation and holds at 255 instead of wrapping.
- R9: When `cnt_rd_i` is sampled high, `rd_data_o` takes the counter value of that cycle and the counter restarts at 0. A violation in the same cycle leaves it at 1.
- R10: When `cnt_clr_i` is sampled high, the counter becomes 0, even if a violation occurs in the same cycle.
- R11: In NRZ mode, `cnt_o` changes only through R9 or R10.
- R12: `line_clk_o` is the inverse of `clk_i` when `dual_rail_i` and `clk_inv_i` are both 1. In every other case it equals `clk_i`.
- R13: The first single-rail pulse after reset, or after NRZ mode, is never a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dual_rail_i | input | 1 | 1 selects dual-rail HDB3 input, 0 selects NRZ input |
| pos_i | input | 1 | Positive pulse rail |
| neg_i | input | 1 | Negative pulse rail |
| nrz_i | input | 1 | NRZ data input |
| clk_inv_i | input | 1 | Inverts `line_clk_o` in dual-rail mode |
| cnt_rd_i | input | 1 | Read-and-clear strobe for the violation counter |
| cnt_clr_i | input | 1 | Counter clear |
| data_o | output | 1 | Decoded NRZ data |
| cv_o | output | 1 | Illegal violation pulse |
| cnt_o | output | CNT_W | Live violation count |
| rd_data_o | output | CNT_W | Counter value captured by the last read strobe |
| line_clk_o | output | 1 | Line clock, optionally inverted |

## Verification
A decoded bit is due on `data_o` three edges after the edge that sampled it. `cv_o` and the counter answer one edge after the offending sample, and `rd_data_o` one edge after the strobe. The bench drives each line symbol on a falling edge and keeps a record of the expected bit and flag for every symbol. On each later falling edge it compares `data_o` against the entry four symbols back and `cv_o` against the entry one symbol back. Counter values are read one full cycle after the last stimulus that can touch them. `line_clk_o` is checked at a point where the clock level is known.

// File: rtl/hdb3_pkg.sv
package hdb3_pkg;
  // V plus the three bit periods it may overwrite
  localparam int unsigned ALIGN_DEPTH = 4;
  localparam int unsigned HIST_W      = 2;

  typedef struct packed {
    logic mark;  // either rail high
    logic pos;   // positive rail high
    logic both;  // both rails high
  } line_sym_t;
endpackage

// File: rtl/hdb3_line_mux.sv
module hdb3_line_mux
  import hdb3_pkg::*;
(
  input  logic      clk_i,
  input  logic      dual_rail_i,
  input  logic      clk_inv_i,
  input  logic      pos_i,
  input  logic      neg_i,
  output line_sym_t sym_o,
  output logic      line_clk_o
);
  always_comb begin
    sym_o.mark = pos_i | neg_i;
    sym_o.pos  = pos_i;
    sym_o.both = pos_i & neg_i;
  end

  assign line_clk_o = clk_i ^ (dual_rail_i & clk_inv_i);
endmodule

// File: rtl/hdb3_decode_core.sv
module hdb3_decode_core
  import hdb3_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      dual_rail_i,
  input  line_sym_t sym_i,
  input  logic      nrz_i,
  output logic      data_o,
  output logic      cv_o,
  output logic      cv_evt_o
);
  logic [ALIGN_DEPTH-1:0] dq_q, dq_d;
  logic [HIST_W-1:0]      mk_q;
  logic                   pol_q, seen_q;
  logic                   single, same_pol, quiet, v_ok, in_bit;

  always_comb begin
    single   = sym_i.mark & ~sym_i.both;
    same_pol = dual_rail_i & single & seen_q & (sym_i.pos == pol_q);
    quiet    = (mk_q == '0);
    v_ok     = same_pol & quiet;
    cv_evt_o = dual_rail_i & ((same_pol & ~quiet) | sym_i.both);
    in_bit   = dual_rail_i ? (sym_i.mark & ~v_ok) : nrz_i;
    // a substitution wipes every older bit still inside the alignment window
    if (v_ok) dq_d = {{(ALIGN_DEPTH-1){1'b0}}, in_bit};
    else      dq_d = {dq_q[ALIGN_DEPTH-2:0], in_bit};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_q   <= '0;
      mk_q   <= '0;
      pol_q  <= 1'b0;
      seen_q <= 1'b0;
      cv_o   <= 1'b0;
    end else begin
      dq_q <= dq_d;
      cv_o <= cv_evt_o;
      if (dual_rail_i) begin
        mk_q <= {mk_q[HIST_W-2:0], sym_i.mark};
        if (single) begin
          pol_q  <= sym_i.pos;
          seen_q <= 1'b1;
        end
      end else begin
        mk_q   <= '0;
        seen_q <= 1'b0;
      end
    end
  end

  assign data_o = dq_q[ALIGN_DEPTH-1];
endmodule

// File: rtl/hdb3_cv_counter.sv
module hdb3_cv_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             rd_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rd_data_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o     <= '0;
      rd_data_o <= '0;
    end else begin
      if (rd_i) rd_data_o <= cnt_o;
      if (clr_i)                         cnt_o <= '0;
      else if (rd_i)                     cnt_o <= {{(CNT_W-1){1'b0}}, evt_i};
      else if (evt_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/hdb3_rx_decoder.sv
module hdb3_rx_decoder
  import hdb3_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dual_rail_i,
  input  logic             pos_i,
  input  logic             neg_i,
  input  logic             nrz_i,
  input  logic             clk_inv_i,
  input  logic             cnt_rd_i,
  input  logic             cnt_clr_i,
  output logic             data_o,
  output logic             cv_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             line_clk_o
);
  line_sym_t sym;
  logic      cv_evt;

  hdb3_line_mux u_mux (
    .clk_i       (clk_i),
    .dual_rail_i (dual_rail_i),
    .clk_inv_i   (clk_inv_i),
    .pos_i       (pos_i),
    .neg_i       (neg_i),
    .sym_o       (sym),
    .line_clk_o  (line_clk_o)
  );

  hdb3_decode_core u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dual_rail_i (dual_rail_i),
    .sym_i       (sym),
    .nrz_i       (nrz_i),
    .data_o      (data_o),
    .cv_o        (cv_o),
    .cv_evt_o    (cv_evt)
  );

  hdb3_cv_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (cv_evt),
    .rd_i      (cnt_rd_i),
    .clr_i     (cnt_clr_i),
    .cnt_o     (cnt_o),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/hdb3_rx_decoder_chk.sv
module hdb3_rx_decoder_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dual_rail_i,
  input logic             pos_i,
  input logic             neg_i,
  input logic             cnt_rd_i,
  input logic             cnt_clr_i,
  input logic             cv_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W-1:0] rd_data_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  a_r6_both_rails: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dual_rail_i && pos_i && neg_i) |=> cv_o);

  a_r7_nrz_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dual_rail_i |=> !cv_o);

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX && !cnt_rd_i && !cnt_clr_i) |=> cnt_o == CNT_MAX);

  a_r8_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_rd_i && !cnt_clr_i) |=>
      (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1));

  a_r9_read_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rd_i && !cnt_clr_i) |=> (rd_data_o == $past(cnt_o) && cnt_o <= 1));

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> cnt_o == '0);

  a_r11_nrz_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dual_rail_i && !cnt_rd_i && !cnt_clr_i) |=> $stable(cnt_o));
endmodule

bind hdb3_rx_decoder hdb3_rx_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dual_rail_i (dual_rail_i),
  .pos_i       (pos_i),
  .neg_i       (neg_i),
  .cnt_rd_i    (cnt_rd_i),
  .cnt_clr_i   (cnt_clr_i),
  .cv_o        (cv_o),
  .cnt_o       (cnt_o),
  .rd_data_o   (rd_data_o)
);

// File: tb/tb_hdb3_rx_decoder.sv
`timescale 1ns/1ps
module tb_hdb3_rx_decoder;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       dual_rail_i = 1'b0, pos_i = 1'b0, neg_i = 1'b0, nrz_i = 1'b0;
  logic       clk_inv_i = 1'b0, cnt_rd_i = 1'b0, cnt_clr_i = 1'b0;
  logic       data_o, cv_o, line_clk_o;
  logic [7:0] cnt_o, rd_data_o;

  int checks = 0, fails = 0, idx = 0;
  bit done = 0;
  logic ed [0:1023];
  logic ev [0:1023];
  logic src [0:1023];
  logic lp [0:1023];
  logic ln [0:1023];

  always #10 clk_i = ~clk_i;  // 50 MHz

  hdb3_rx_decoder dut (.*);

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic dual);
    @(negedge clk_i);
    rst_ni = 1'b0; dual_rail_i = dual;
    pos_i = 0; neg_i = 0; nrz_i = 0; cnt_rd_i = 0; cnt_clr_i = 0; clk_inv_i = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    idx = 0;
  endtask

  // drive one symbol at a falling edge after checking outputs due now
  task automatic step(input logic p, n, nz, rd, clr, eb, evl, input string tag);
    @(negedge clk_i);
    check({tag, " data"}, int'(data_o), (idx >= 4) ? int'(ed[idx-4]) : 0);
    check("R7 cv", int'(cv_o), (idx >= 1) ? int'(ev[idx-1]) : 0);
    pos_i = p; neg_i = n; nrz_i = nz; cnt_rd_i = rd; cnt_clr_i = clr;
    ed[idx] = eb; ev[idx] = evl;
    idx++;
  endtask

  task automatic flush(input string tag);
    repeat (4) step(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // reference HDB3 encoder over src[0:n-1]
  task automatic encode(input int n);
    logic last_pos = 1'b0;
    bit   odd = 0;
    int   i = 0;
    while (i < n) begin
      if (i + 3 < n && !src[i] && !src[i+1] && !src[i+2] && !src[i+3]) begin
        for (int j = 0; j < 4; j++) begin lp[i+j] = 0; ln[i+j] = 0; end
        if (!odd) begin
          last_pos = ~last_pos;
          lp[i] = last_pos; ln[i] = ~last_pos;
        end
        lp[i+3] = last_pos; ln[i+3] = ~last_pos;
        odd = 0;
        i += 4;
      end else if (src[i]) begin
        last_pos = ~last_pos;
        lp[i] = last_pos; ln[i] = ~last_pos;
        odd = ~odd;
        i++;
      end else begin
        lp[i] = 0; ln[i] = 0;
        i++;
      end
    end
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    rst_ni = 1'b0; dual_rail_i = 1; pos_i = 1; neg_i = 1; cnt_rd_i = 1;
    repeat (2) @(negedge clk_i);
    check("R1 data", int'(data_o), 0);
    check("R1 cv", int'(cv_o), 0);
    check("R1 cnt", int'(cnt_o), 0);
    check("R1 rd_data", int'(rd_data_o), 0);
  endtask

  task automatic t_nrz;
    do_reset(0);
    for (int i = 0; i < 200; i++) begin
      logic b = 1'($urandom);
      step(1'($urandom), 1'($urandom), b, 0, 0, b, 0, "R2");
    end
    flush("R2");
    check("R11 cnt", int'(cnt_o), 0);
  endtask

  task automatic t_hdb3_stream(input int n, input bit rnd);
    do_reset(1);
    for (int i = 0; i < n; i++)
      src[i] = rnd ? (($urandom % 3) == 0) : 1'b0;
    if (!rnd) begin src[0] = 1; src[5] = 1; end
    encode(n);
    for (int i = 0; i < n; i++)
      step(lp[i], ln[i], 0, 0, 0, src[i], 0, "R4");
    flush("R3");
    check("R4 no count", int'(cnt_o), 0);
  endtask

  task automatic t_illegal;
    do_reset(1);
    step(1, 0, 0, 0, 0, 1, 0, "R13");  // first pulse
    step(0, 0, 0, 0, 0, 0, 0, "R3");
    step(1, 0, 0, 0, 0, 1, 1, "R5");   // mark two periods back
    step(1, 0, 0, 0, 0, 1, 1, "R5");   // adjacent same polarity
    step(0, 1, 0, 0, 0, 1, 0, "R3");
    step(1, 1, 0, 0, 0, 1, 1, "R6");   // both rails
    step(1, 0, 0, 0, 0, 1, 0, "R6");   // polarity record still negative
    flush("R5");
    check("R8 count after illegal", int'(cnt_o), 3);
  endtask

  task automatic t_saturate;
    do_reset(1);
    for (int i = 0; i < 260; i++) step(1, 1, 0, 0, 0, 1, 1, "R6");
    flush("R8");
    check("R8 saturate", int'(cnt_o), 255);
    step(0, 0, 0, 1, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 0, "R9");
    check("R9 rd_data", int'(rd_data_o), 255);
    check("R9 cleared", int'(cnt_o), 0);
  endtask

  task automatic t_coincide;
    do_reset(1);
    repeat (3) step(1, 1, 0, 0, 0, 1, 1, "R6");
    step(0, 0, 0, 0, 0, 0, 0, "R8");
    check("R8 count", int'(cnt_o), 3);
    step(1, 1, 0, 1, 0, 1, 1, "R9");
    step(0, 0, 0, 0, 0, 0, 0, "R9");
    check("R9 rd_data", int'(rd_data_o), 3);
    check("R9 restart", int'(cnt_o), 1);
    step(1, 1, 0, 0, 1, 1, 1, "R10");
    step(0, 0, 0, 0, 0, 0, 0, "R10");
    check("R10 clear wins", int'(cnt_o), 0);
    step(1, 1, 0, 0, 0, 1, 1, "R8");
    flush("R8");
    check("R8 resume", int'(cnt_o), 1);
  endtask

  task automatic t_line_clk;
    @(negedge clk_i);
    dual_rail_i = 1; clk_inv_i = 1; #1;
    check("R12 inverted", int'(line_clk_o), 1);
    clk_inv_i = 0; #1;
    check("R12 plain", int'(line_clk_o), 0);
    dual_rail_i = 0; clk_inv_i = 1; #1;
    check("R12 nrz ignores invert", int'(line_clk_o), 0);
    clk_inv_i = 0;
  endtask

  initial begin
    t_reset();
    t_nrz();
    t_hdb3_stream(16, 0);
    t_hdb3_stream(400, 1);
    t_illegal();
    t_saturate();
    t_coincide();
    t_line_clk();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule